// File: doc/BRIEF.md
# NAND Flash Raw Page Read Sequencer

This block reads one complete raw page from an 8-bit NAND flash device. The page is 2048 data bytes followed by 64 spare bytes. It is meant for low-level image acquisition, where every stored byte matters, including the metadata bytes and erased regions. A single-cycle start pulse carries a 12-bit column address and a 16-bit page (row) address. The block then drives the open-read command, four address bytes and the confirm command onto the shared bidirectional byte bus, marking each byte type with the command-latch and address-latch strobes.

After the confirm command, the block lets a fixed settle time pass and then polls the device's ready/busy line. It gives up with an error flag if the device never becomes ready. Once the device is ready, the block clocks out 2112 bytes with read-enable pulses and sends each byte out on a simple stream with a valid flag and a last marker. The low time and high time of every write-enable and read-enable pulse come from two configuration inputs, counted in system clocks. Write protect is held asserted for the whole time.

Top module: `nand_page_reader`

## Requirements
- R1: An accepted start produces exactly six write-enable pulses, in this order: command 0x00 with the command-latch strobe high, four address bytes with the address-latch strobe high, and command 0x30 with the command-latch strobe high. Chip enable (active low) stays low from the first pulse until the read ends.
- R2: The address bytes are, in order: column[7:0], then {4'b0000, column[11:8]}, then row[7:0], then row[15:8].
- R3: Every write-enable and read-enable pulse stays low for exactly `pulse_lo` clocks, and a value of 0 counts as 1. Between two pulses of the same strobe, the strobe stays high for at least `pulse_hi` clocks, and a value of 0 again counts as 1. The two strobes are never low together.
- R4: No read-enable pulse begins earlier than SETTLE_CYC clocks after the rising write-enable edge of the confirm command, or while ready/busy is low.
- R5: The block drives the byte bus only during the command and address phases. It leaves the bus undriven while waiting and during data-out, so read data travels unharmed.
- R6: Exactly 2112 read-enable pulses are issued. The bus is sampled at each rising read-enable edge, and the bytes are presented in order, one per `rd_valid` cycle. Erased bytes (0xFF) pass through unchanged.
- R7: `rd_last` is high together with `rd_valid` on the 2112th byte only. After that, `busy` falls and chip enable returns high.
- R8: A start that arrives while `busy` is high is ignored. The latched address, the command sequence and the byte stream are left unchanged.
- R9: If ready/busy stays low for TMO_CYC polling clocks, the read is aborted. `err_timeout` goes high, chip enable goes high, no byte is streamed, and the next accepted start clears `err_timeout`.
- R10: During and just after reset: chip enable, write enable and read enable are high, both latch strobes are low, the bus is undriven, and `busy`, `rd_valid` and `err_timeout` are low.
- R11: Write protect (`nf_wp_n`) is low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to read a page |
| col_addr | input | 12 | Column at which the device starts streaming |
| row_addr | input | 16 | Page address |
| pulse_lo | input | CFG_W | Strobe low time in clocks (0 counts as 1) |
| pulse_hi | input | CFG_W | Minimum strobe high time in clocks (0 counts as 1) |
| nf_io | inout | 8 | Shared command/address/data bus |
| nf_cle | output | 1 | Command-latch strobe |
| nf_ale | output | 1 | Address-latch strobe |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_we_n | output | 1 | Write enable, active low |
| nf_re_n | output | 1 | Read enable, active low |
| nf_wp_n | output | 1 | Write protect, active low, always asserted |
| nf_rb_n | input | 1 | Ready (1) / busy (0) from the device |
| rd_data | output | 8 | Streamed byte |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| rd_last | output | 1 | Marks byte 2111 |
| busy | output | 1 | A read is in progress |
| err_timeout | output | 1 | The last read aborted because the device never became ready |

## Verification
The bench models a device that checks the command and address bytes and streams a page whose spare region is all 0xFF. If the second address byte carried stray upper bits, or a command were missing or misordered, the logged byte sequence would not match. If the byte counter were off by one, a byte would be lost or an extra one streamed, or `rd_last` would sit on the wrong byte. Strobe widths are measured on every pulse with several `pulse_lo`/`pulse_hi` settings, including zero, so an error in the low-time reload would show up as a wrong pulse width. A stray start during data-out, a device that stays busy, and the read after that abort target the cases where a careless design would restart, hang or keep a stale error flag.

// File: rtl/nfr_pkg.sv
package nfr_pkg;

    localparam int unsigned BUS_W      = 8;
    localparam int unsigned COL_W      = 12;
    localparam int unsigned ROW_W      = 16;
    localparam int unsigned ADDR_BYTES = 4;

    localparam logic [BUS_W-1:0] OP_OPEN_READ = 8'h00;
    localparam logic [BUS_W-1:0] OP_CONFIRM   = 8'h30;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_OPEN,
        SQ_ADDR,
        SQ_CONF,
        SQ_WAIT,
        SQ_DATA
    } seq_state_t;

    typedef enum logic [1:0] {
        PG_IDLE,
        PG_LOW,
        PG_HIGH
    } pulse_state_t;

    typedef enum logic [1:0] {
        RW_OFF,
        RW_SETTLE,
        RW_POLL
    } wait_state_t;

    typedef struct packed {
        logic             cle;
        logic             ale;
        logic             oe;
        logic [BUS_W-1:0] dout;
    } bus_drive_t;

    // Address byte for bus cycle idx; cycle 1 carries only four column bits.
    function automatic logic [BUS_W-1:0] addr_byte(
        input logic [1:0]       idx,
        input logic [COL_W-1:0] col,
        input logic [ROW_W-1:0] row
    );
        logic [BUS_W-1:0] b;
        case (idx)
            2'd0:    b = col[7:0];
            2'd1:    b = {4'b0000, col[11:8]};
            2'd2:    b = row[7:0];
            default: b = row[15:8];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/nfr_pulse_gen.sv
module nfr_pulse_gen
    import nfr_pkg::*;
#(
    parameter int unsigned CFG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [CFG_W-1:0] lo_cyc,
    input  logic [CFG_W-1:0] hi_cyc,
    output logic             strobe_n,
    output logic             rise,
    output logic             done
);

    pulse_state_t     st;
    logic [CFG_W-1:0] cnt;
    logic [CFG_W-1:0] lo_m1;
    logic [CFG_W-1:0] hi_m1;

    assign lo_m1 = (lo_cyc == '0) ? '0 : lo_cyc - 1'b1;
    assign hi_m1 = (hi_cyc == '0) ? '0 : hi_cyc - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PG_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                PG_IDLE: begin
                    if (go) begin
                        st  <= PG_LOW;
                        cnt <= lo_m1;
                    end
                end
                PG_LOW: begin
                    if (cnt == '0) begin
                        st  <= PG_HIGH;
                        cnt <= hi_m1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PG_HIGH: begin
                    if (cnt == '0) st <= PG_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= PG_IDLE;
            endcase
        end
    end

    assign strobe_n = (st != PG_LOW);
    assign rise     = (st == PG_LOW)  && (cnt == '0);
    assign done     = (st == PG_HIGH) && (cnt == '0);

    AST_RISE_ENDS_LOW: assert property (@(posedge clk) disable iff (rst)
        rise |=> (strobe_n && !rise)); // R3
    AST_LOW_NEEDS_GO: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_n) |-> $past(go)); // R3

endmodule

// File: rtl/nfr_ready_wait.sv
module nfr_ready_wait
    import nfr_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 8,
    parameter int unsigned TMO_CYC    = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic rb_n,
    output logic ready,
    output logic timeout
);

    localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
    localparam int unsigned TW = $clog2(TMO_CYC + 1);

    wait_state_t st;
    logic [SW-1:0] scnt;
    logic [TW-1:0] tcnt;

    assign ready   = (st == RW_POLL) && rb_n;
    assign timeout = (st == RW_POLL) && !rb_n && (tcnt == TW'(TMO_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= RW_OFF;
            scnt <= '0;
            tcnt <= '0;
        end else begin
            case (st)
                RW_OFF: begin
                    if (arm) begin
                        st   <= RW_SETTLE;
                        scnt <= '0;
                    end
                end
                RW_SETTLE: begin
                    if (scnt == SW'(SETTLE_CYC - 1)) begin
                        st   <= RW_POLL;
                        tcnt <= '0;
                    end else begin
                        scnt <= scnt + 1'b1;
                    end
                end
                RW_POLL: begin
                    if (ready || timeout) st <= RW_OFF;
                    else                  tcnt <= tcnt + 1'b1;
                end
                default: st <= RW_OFF;
            endcase
        end
    end

    AST_POLL_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
        (st == RW_SETTLE && $past(st) == RW_OFF) |-> $past(arm)); // R4

endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
    import nfr_pkg::*;
#(
    parameter int unsigned CFG_W      = 4,
    parameter int unsigned PAGE_BYTES = 2112,
    parameter int unsigned SETTLE_CYC = 8,
    parameter int unsigned TMO_CYC    = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [11:0]      col_addr,
    input  logic [15:0]      row_addr,
    input  logic [CFG_W-1:0] pulse_lo,
    input  logic [CFG_W-1:0] pulse_hi,
    inout  wire  [7:0]       nf_io,
    output logic             nf_cle,
    output logic             nf_ale,
    output logic             nf_ce_n,
    output logic             nf_we_n,
    output logic             nf_re_n,
    output logic             nf_wp_n,
    input  logic             nf_rb_n,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             rd_last,
    output logic             busy,
    output logic             err_timeout
);

    localparam int unsigned BCW    = $clog2(PAGE_BYTES + 1);
    localparam int unsigned NSTRB  = 2;
    localparam int unsigned IX_WE  = 0;
    localparam int unsigned IX_RE  = 1;

    seq_state_t       state;
    logic [1:0]       addr_idx;
    logic [BCW-1:0]   byte_cnt;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    bus_drive_t       drv;

    logic [NSTRB-1:0] pg_go;
    logic [NSTRB-1:0] pg_strobe_n;
    logic [NSTRB-1:0] pg_rise;
    logic [NSTRB-1:0] pg_done;

    logic wait_arm;
    logic wait_ready;
    logic wait_tmo;

    // One pulse timer per strobe: index 0 is write enable, index 1 read enable.
    generate
        for (genvar g = 0; g < NSTRB; g++) begin : g_strobe
            nfr_pulse_gen #(.CFG_W(CFG_W)) u_pg (
                .clk      (clk),
                .rst      (rst),
                .go       (pg_go[g]),
                .lo_cyc   (pulse_lo),
                .hi_cyc   (pulse_hi),
                .strobe_n (pg_strobe_n[g]),
                .rise     (pg_rise[g]),
                .done     (pg_done[g])
            );
        end
    endgenerate

    nfr_ready_wait #(
        .SETTLE_CYC (SETTLE_CYC),
        .TMO_CYC    (TMO_CYC)
    ) u_wait (
        .clk     (clk),
        .rst     (rst),
        .arm     (wait_arm),
        .rb_n    (nf_rb_n),
        .ready   (wait_ready),
        .timeout (wait_tmo)
    );

    assign pg_go[IX_WE] = (state == SQ_OPEN) || (state == SQ_ADDR) || (state == SQ_CONF);
    assign pg_go[IX_RE] = (state == SQ_DATA);
    assign wait_arm     = (state == SQ_CONF) && pg_done[IX_WE];

    always_comb begin
        drv = '{cle: 1'b0, ale: 1'b0, oe: 1'b0, dout: '0};
        case (state)
            SQ_OPEN: drv = '{cle: 1'b1, ale: 1'b0, oe: 1'b1, dout: OP_OPEN_READ};
            SQ_ADDR: drv = '{cle: 1'b0, ale: 1'b1, oe: 1'b1,
                             dout: addr_byte(addr_idx, col_q, row_q)};
            SQ_CONF: drv = '{cle: 1'b1, ale: 1'b0, oe: 1'b1, dout: OP_CONFIRM};
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SQ_IDLE;
            addr_idx    <= '0;
            byte_cnt    <= '0;
            col_q       <= '0;
            row_q       <= '0;
            rd_data     <= '0;
            rd_valid    <= 1'b0;
            rd_last     <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        col_q       <= col_addr;
                        row_q       <= row_addr;
                        err_timeout <= 1'b0;
                        state       <= SQ_OPEN;
                    end
                end
                SQ_OPEN: begin
                    if (pg_done[IX_WE]) begin
                        addr_idx <= '0;
                        state    <= SQ_ADDR;
                    end
                end
                SQ_ADDR: begin
                    if (pg_done[IX_WE]) begin
                        addr_idx <= addr_idx + 1'b1;
                        if (addr_idx == 2'(ADDR_BYTES - 1)) state <= SQ_CONF;
                    end
                end
                SQ_CONF: begin
                    if (pg_done[IX_WE]) state <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (wait_ready) begin
                        byte_cnt <= '0;
                        state    <= SQ_DATA;
                    end else if (wait_tmo) begin
                        err_timeout <= 1'b1;
                        state       <= SQ_IDLE;
                    end
                end
                SQ_DATA: begin
                    if (pg_rise[IX_RE]) begin
                        rd_data  <= nf_io;
                        rd_valid <= 1'b1;
                        rd_last  <= (byte_cnt == BCW'(PAGE_BYTES - 1));
                        byte_cnt <= byte_cnt + 1'b1;
                    end
                    if (pg_done[IX_RE] && byte_cnt == BCW'(PAGE_BYTES)) state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign nf_io   = drv.oe ? drv.dout : 8'hzz;
    assign nf_cle  = drv.cle;
    assign nf_ale  = drv.ale;
    assign nf_ce_n = (state == SQ_IDLE);
    assign nf_we_n = pg_strobe_n[IX_WE];
    assign nf_re_n = pg_strobe_n[IX_RE];
    assign nf_wp_n = 1'b0;
    assign busy    = (state != SQ_IDLE);

    AST_CE_DURING_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!nf_we_n || !nf_re_n) |-> !nf_ce_n); // R1
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!nf_we_n && !nf_re_n)); // R3
    AST_RE_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        $fell(nf_re_n) |-> nf_rb_n); // R4
    AST_BUS_FREE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !nf_re_n |-> !drv.oe); // R5
    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> rd_valid); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(row_q) && $stable(col_q))); // R8
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_timeout) |-> (!busy && !rd_valid)); // R9

endmodule

// File: tb/sim_nand_page_reader.sv
module sim_nand_page_reader;

    localparam int PAGE   = 2112;
    localparam int DATA_N = 2048;
    localparam int SETTLE = 8;
    localparam int TMO    = 400;
    localparam int BUSYC  = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] col_addr = '0;
    logic [15:0] row_addr = '0;
    logic [3:0]  pulse_lo = 4'd1;
    logic [3:0]  pulse_hi = 4'd1;
    wire  [7:0]  nf_io;
    logic nf_cle, nf_ale, nf_ce_n, nf_we_n, nf_re_n, nf_wp_n, nf_rb_n;
    logic [7:0]  rd_data;
    logic rd_valid, rd_last, busy, err_timeout;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nand_page_reader #(
        .CFG_W(4), .PAGE_BYTES(PAGE), .SETTLE_CYC(SETTLE), .TMO_CYC(TMO)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .col_addr(col_addr), .row_addr(row_addr),
        .pulse_lo(pulse_lo), .pulse_hi(pulse_hi), .nf_io(nf_io),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_ce_n(nf_ce_n), .nf_we_n(nf_we_n),
        .nf_re_n(nf_re_n), .nf_wp_n(nf_wp_n), .nf_rb_n(nf_rb_n),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_last(rd_last),
        .busy(busy), .err_timeout(err_timeout)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] page_byte(input logic [15:0] row, input int idx);
        logic [10:0] i;
        i = 11'(idx);
        if (idx >= DATA_N) return 8'hFF;
        return (i[7:0] ^ (8'(i[10:8]) * 8'd37) ^ row[7:0]) + row[15:8];
    endfunction

    // Device model state, all owned by the single negedge process below.
    logic [7:0]  dev_byte = '0;
    int          dev_ptr = 0;
    logic [15:0] dev_row = '0;
    bit          dev_armed = 0;
    bit          dev_hang = 0;
    int          conf_cyc = 0;
    logic [9:0]  cmd_log[$];
    logic [7:0]  exp_q[$];
    int          got_bytes = 0;
    bit          first_re_pending = 0;

    assign nf_io   = (!nf_ce_n && !nf_re_n) ? dev_byte : 8'hzz;
    assign nf_rb_n = !dev_armed || (!dev_hang && (cyc - conf_cyc >= BUSYC));

    logic prev_we = 1'b1, prev_re = 1'b1;
    int   we_lo = 0, re_lo = 0, we_hi = 0, re_hi = 0;
    bit   we_seen = 0, re_seen = 0;

    always @(negedge clk) begin
        if (!rst) begin
            int lo_eff;
            int hi_eff;
            lo_eff = (pulse_lo == 0) ? 1 : int'(pulse_lo);
            hi_eff = (pulse_hi == 0) ? 1 : int'(pulse_hi);
            if (nf_wp_n !== 1'b0) chk(0, "R11", "write protect", nf_wp_n, 0);
            // write-enable pulse shape
            if (!nf_we_n) begin
                if (prev_we && we_seen) chk(we_hi >= hi_eff, "R3", "WE high gap", we_hi, hi_eff);
                we_lo++; we_hi = 0;
            end else begin
                if (!prev_we) begin
                    chk(we_lo == lo_eff, "R3", "WE low width", we_lo, lo_eff);
                    we_seen = 1;
                    cmd_log.push_back({nf_cle, nf_ale, nf_io});
                    if (nf_cle && nf_io == 8'h30) begin
                        dev_armed = 1;
                        conf_cyc = cyc;
                        dev_col_load();
                        first_re_pending = 1;
                    end
                end
                we_lo = 0; we_hi++;
            end
            // read-enable pulse shape and device pointer
            if (!nf_re_n) begin
                if (prev_re && re_seen) chk(re_hi >= hi_eff, "R3", "RE high gap", re_hi, hi_eff);
                if (prev_re) begin
                    chk(nf_rb_n == 1'b1, "R4", "RE while busy", nf_rb_n, 1);
                    if (first_re_pending) begin
                        chk(cyc - conf_cyc >= SETTLE, "R4", "settle before RE", cyc - conf_cyc, SETTLE);
                        first_re_pending = 0;
                    end
                end
                re_lo++; re_hi = 0;
            end else begin
                if (!prev_re) begin
                    chk(re_lo == lo_eff, "R3", "RE low width", re_lo, lo_eff);
                    re_seen = 1;
                    dev_ptr = (dev_ptr + 1) % PAGE;
                end
                re_lo = 0; re_hi++;
            end
            dev_byte = page_byte(dev_row, dev_ptr);
            prev_we = nf_we_n;
            prev_re = nf_re_n;
            // output stream against the reference queue
            if (rd_valid) begin
                got_bytes++;
                if (exp_q.size() == 0) begin
                    chk(0, "R6", "extra byte", rd_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R5 R6", "stream byte", rd_data, e);
                    chk(rd_last == (exp_q.size() == 0), "R7", "last flag", rd_last, exp_q.size() == 0);
                end
            end else if (rd_last) begin
                chk(0, "R7", "last without valid", rd_last, 0);
            end
        end
    end

    task automatic dev_col_load();
        logic [11:0] c;
        c = {cmd_log[2][3:0], cmd_log[1][7:0]};
        dev_row = {cmd_log[4][7:0], cmd_log[3][7:0]};
        dev_ptr = int'(c) % PAGE;
    endtask

    task automatic pulse_start(input logic [15:0] row, input logic [11:0] col);
        @(negedge clk);
        row_addr = row; col_addr = col; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_read(input logic [15:0] row, input logic [11:0] col,
                            input logic [3:0] lo, input logic [3:0] hi, input bit stray);
        logic [9:0] exp_log[6];
        int lim;
        pulse_lo = lo; pulse_hi = hi;
        cmd_log.delete();
        got_bytes = 0;
        for (int k = 0; k < PAGE; k++) exp_q.push_back(page_byte(row, (int'(col) + k) % PAGE));
        pulse_start(row, col);
        chk(busy == 1'b1 && err_timeout == 1'b0, "R9", "busy and error cleared after start",
            {busy, err_timeout}, 2'b10);
        if (stray) begin
            lim = 0;
            while (got_bytes < 100 && lim < 20000) begin @(negedge clk); lim++; end
            pulse_start(16'hFFFF, 12'hFFF);  // R8: ignored while busy
        end
        lim = 0;
        while (busy && lim < 60000) begin @(negedge clk); lim++; end
        repeat (3) @(negedge clk);
        chk(got_bytes == PAGE, "R6", "byte count", got_bytes, PAGE);
        chk(exp_q.size() == 0, "R6", "bytes missing", exp_q.size(), 0);
        chk(busy == 1'b0 && nf_ce_n == 1'b1, "R7", "idle after last", {busy, nf_ce_n}, 2'b01);
        exp_log[0] = {2'b10, 8'h00};
        exp_log[1] = {2'b01, col[7:0]};
        exp_log[2] = {2'b01, 4'b0000, col[11:8]};
        exp_log[3] = {2'b01, row[7:0]};
        exp_log[4] = {2'b01, row[15:8]};
        exp_log[5] = {2'b10, 8'h30};
        chk(cmd_log.size() == 6, stray ? "R8" : "R1", "bus cycle count", cmd_log.size(), 6);
        for (int k = 0; k < 6 && k < cmd_log.size(); k++)
            chk(cmd_log[k] == exp_log[k], (k >= 1 && k <= 4) ? "R2" : "R1", "bus cycle",
                cmd_log[k], exp_log[k]);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale, "R10", "strobes in reset",
            {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale}, 5'b11100);
        chk(!busy && !rd_valid && !err_timeout, "R10", "status in reset",
            {busy, rd_valid, err_timeout}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(nf_ce_n && nf_we_n && nf_re_n && !busy, "R10", "idle after reset",
            {nf_ce_n, nf_we_n, nf_re_n, busy}, 4'b1110);
        chk(nf_wp_n == 1'b0, "R11", "write protect", nf_wp_n, 0);

        run_read(16'h1234, 12'h000, 4'd1, 4'd1, 0);   // R1 R2 R6 R7
        run_read(16'hBEEF, 12'h5A7, 4'd3, 4'd2, 1);   // R2 R3 R8, spare 0xFF in the middle
        run_read(16'h00C3, 12'h7FF, 4'd0, 4'd0, 0);   // R3 zero counts as one

        // R9: device stays busy
        dev_hang = 1;
        cmd_log.delete();
        got_bytes = 0;
        pulse_start(16'h0042, 12'h010);
        begin
            int lim;
            lim = 0;
            while (busy && lim < 5000) begin @(negedge clk); lim++; end
        end
        chk(err_timeout == 1'b1, "R9", "timeout flag", err_timeout, 1);
        chk(nf_ce_n == 1'b1 && !busy, "R9", "aborted to idle", {nf_ce_n, busy}, 2'b10);
        chk(got_bytes == 0, "R9", "no bytes on abort", got_bytes, 0);
        dev_hang = 0;
        repeat (5) @(negedge clk);
        chk(err_timeout == 1'b1, "R9", "flag held until next start", err_timeout, 1);
        run_read(16'h0042, 12'h010, 4'd2, 4'd1, 0);   // R9 clears on new start

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 190000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule